// File: doc/BRIEF.md
# Aligned Segment Splitter

This unit turns a stream of memory segments, each an address and a byte length, into descriptors that a transfer engine can run. No descriptor is longer than a set maximum byte count. When a segment is longer than that, the unit does not cut full-size pieces and leave a short remainder. It works out how many aligned pieces the remaining length needs, with a ceiling division, and emits pieces of nearly equal size with the alignment bits cleared. It then repeats that rule on whatever length is left.

Segments arrive on a valid/ready stream with a last flag that marks the end of a list. Descriptors leave on a valid/ready stream, and their last flag marks the final piece of the list. The unit rejects three kinds of input and raises a one-cycle error: a misaligned start address, a zero-length entry, and a cyclic request with no whole period. It then throws away the rest of that list. It keeps a running byte total for the current list. In cyclic mode a single input entry gives the buffer size, a separate input gives the period length, and the unit splits each whole period in turn. It also reports how many descriptors one period takes. Both divisions run on one shared restoring divider that takes several cycles, and the input stays not-ready while a segment is being worked on.

Top module: `seg_splitter`

## Requirements
- R1: A segment or remaining length of at most MAX_LEN (default 0x1FFF) bytes is emitted unchanged as a single descriptor, at the current address.
- R2: For a remaining length L above MAX_LEN, the piece count is m = ceil(L / LIM), where LIM is MAX_LEN with the ALIGN_MASK bits (default 3) cleared (default 0x1FFC). The piece length is floor(L / m) with the ALIGN_MASK bits cleared, and the rule is applied again to each new remainder.
- R3: Each descriptor's address is the previous descriptor's address plus its length, so the pieces of a segment cover it exactly, and the lengths add up to the segment length.
- R4: A segment whose start address has any ALIGN_MASK bit set makes `err` high for exactly one cycle, on the clock after the segment is accepted. That segment gives no descriptors, and later segments of the same list, up to and including the one with the last flag, are accepted and dropped.
- R5: A zero-length segment is rejected in the same way as in R4.
- R6: `out_last` is 1 only on the final descriptor of a segment that carried `in_last`. In cyclic mode it is 1 only on the final descriptor of the final whole period.
- R7: `total_size` holds the sum of the lengths of the segments accepted so far in the current list. It restarts from the first segment of the next list and reads 0 after a rejected segment.
- R8: When `cyc_mode` is 1 at acceptance, `in_len` is the buffer size and `cyc_period` is the period P. The unit emits floor(size / P) periods. Each period is split by R1/R2 and the addresses continue across periods.
- R9: After the first period of a cyclic request, `period_descs` equals the number of descriptors in one period. A cyclic request with P = 0 or size < P is rejected as in R4.
- R10: `in_ready` is 0 from acceptance of a valid segment until its final descriptor has been taken. While `out_valid` is 1 and `out_ready` is 0, the descriptor is held stable.
- R11: After reset `in_ready` is 1, and `out_valid`, `err` and `total_size` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Segment offered |
| in_ready | output | 1 | Segment accepted this cycle when valid |
| in_addr | input | ADDR_W | Segment start address |
| in_len | input | LEN_W | Segment byte length (buffer size in cyclic mode) |
| in_last | input | 1 | Segment ends its list |
| cyc_mode | input | 1 | Treat segment as a cyclic buffer |
| cyc_period | input | LEN_W | Period length for cyclic mode |
| out_valid | output | 1 | Descriptor available |
| out_ready | input | 1 | Descriptor taken this cycle when valid |
| out_addr | output | ADDR_W | Descriptor address |
| out_len | output | LEN_W | Descriptor byte length |
| out_last | output | 1 | Final descriptor of the list |
| err | output | 1 | One-cycle pulse: rejected segment |
| total_size | output | SUM_W | Running byte total of the current list |
| period_descs | output | LEN_W | Descriptors per cyclic period |

## Verification
`err` and `total_size` are registered on the acceptance edge, so each is due one clock after `in_valid` and `in_ready` are both high. A short segment shows up on `out_valid` two clocks after acceptance. A long piece needs two extra divisions of LEN_W+1 steps each before it shows up. For that reason the bench does not wait a fixed number of cycles for descriptors: it records every handshake at the falling edge before the edge that completes it. It reads results only once `in_ready` is high and `out_valid` low, and an error pulse is counted on the falling edge in the middle of its single high cycle.

// File: rtl/seg_splitter.sv
`timescale 1ns/1ps
module seg_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int SUM_W      = 24,
  parameter int MAX_LEN    = 8191,
  parameter int ALIGN_MASK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_last,
  input  logic              cyc_mode,
  input  logic [LEN_W-1:0]  cyc_period,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_last,
  output logic              err,
  output logic [SUM_W-1:0]  total_size,
  output logic [LEN_W-1:0]  period_descs
);
  localparam int DW  = LEN_W + 1;
  localparam int DCW = $clog2(DW + 1);
  localparam logic [LEN_W-1:0]  MAXL = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0]  AMSK = LEN_W'(ALIGN_MASK);
  localparam logic [ADDR_W-1:0] AMSK_A = ADDR_W'(ALIGN_MASK);
  localparam logic [DW-1:0]     LIM  = DW'(MAX_LEN & ~ALIGN_MASK);

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_SPLIT, S_DIV1, S_DIV2, S_EMIT} st_t;
  st_t st;

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem, chunk, per, size_left, pcnt;
  logic              seg_last, cyc, first_per, list_start;
  logic [DW-1:0]     dq, drem, dvs;
  logic [DCW-1:0]    dcnt;

  logic [DW:0]       r2, r2s;
  logic              ge;
  logic [DW-1:0]     rnx, qnx;

  always_comb begin
    r2  = {drem, dq[DW-1]};
    r2s = r2 - {1'b0, dvs};
    ge  = !r2s[DW];
    rnx = ge ? r2s[DW-1:0] : r2[DW-1:0];
    qnx = {dq[DW-2:0], ge};
  end

  wire take     = in_valid && in_ready;
  wire bad      = ((in_addr & AMSK_A) != '0) || (in_len == '0) ||
                  (cyc_mode && ((cyc_period == '0) || (in_len < cyc_period)));
  wire dfin     = (dcnt == DCW'(DW - 1));
  wire seg_end  = (rem == chunk);
  wire [LEN_W-1:0] left_nx = size_left - per;
  wire more_per = cyc && (left_nx >= per);

  assign in_ready  = (st == S_IDLE) || (st == S_DRAIN);
  assign out_valid = (st == S_EMIT);
  assign out_addr  = cur_addr;
  assign out_len   = chunk;
  assign out_last  = seg_end && seg_last && !more_per;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      err <= 1'b0;
      total_size <= '0;
      period_descs <= '0;
      list_start <= 1'b1;
      cur_addr <= '0;
      rem <= '0;
      chunk <= '0;
      per <= '0;
      size_left <= '0;
      pcnt <= '0;
      seg_last <= 1'b0;
      cyc <= 1'b0;
      first_per <= 1'b0;
      dq <= '0;
      drem <= '0;
      dvs <= '0;
      dcnt <= '0;
    end else begin
      err <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          list_start <= in_last;
          if (bad) begin
            err <= 1'b1;
            total_size <= '0;
            st <= in_last ? S_IDLE : S_DRAIN;
          end else begin
            total_size <= (list_start ? '0 : total_size) + SUM_W'(in_len);
            cur_addr <= in_addr;
            rem <= cyc_mode ? cyc_period : in_len;
            size_left <= in_len;
            per <= cyc_period;
            cyc <= cyc_mode;
            seg_last <= in_last;
            pcnt <= '0;
            first_per <= 1'b1;
            if (cyc_mode) period_descs <= '0;
            st <= S_SPLIT;
          end
        end
        S_DRAIN: if (take) begin
          list_start <= in_last;
          if (in_last) st <= S_IDLE;
        end
        S_SPLIT: begin
          if (rem <= MAXL) begin
            chunk <= rem;
            st <= S_EMIT;
          end else begin
            dq <= DW'(rem) + LIM - DW'(1);
            drem <= '0;
            dvs <= LIM;
            dcnt <= '0;
            st <= S_DIV1;
          end
        end
        S_DIV1, S_DIV2: begin
          dq <= qnx;
          drem <= rnx;
          dcnt <= dcnt + DCW'(1);
          if (dfin) begin
            if (st == S_DIV1) begin
              dq <= DW'(rem);
              drem <= '0;
              dvs <= qnx;
              dcnt <= '0;
              st <= S_DIV2;
            end else begin
              chunk <= qnx[LEN_W-1:0] & ~AMSK;
              st <= S_EMIT;
            end
          end
        end
        S_EMIT: if (out_ready) begin
          cur_addr <= cur_addr + ADDR_W'(chunk);
          rem <= rem - chunk;
          pcnt <= pcnt + LEN_W'(1);
          if (seg_end) begin
            if (cyc) begin
              size_left <= left_nx;
              if (first_per) begin
                period_descs <= pcnt + LEN_W'(1);
                first_per <= 1'b0;
              end
            end
            if (more_per) begin
              rem <= per;
              st <= S_SPLIT;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            st <= S_SPLIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module seg_splitter_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_LEN    = 8191,
  parameter int ALIGN_MASK = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_last,
  input logic              err
);
  // R10: descriptor held while stalled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_last));
  // R10: no new segment taken while a descriptor is pending
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R1: every descriptor is non-empty and within the maximum
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_len <= LEN_W'(MAX_LEN)));
  // R3: addresses stay aligned
  a_r3_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr & ADDR_W'(ALIGN_MASK)) == '0);
  // R4: a rejection never coincides with a descriptor
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);
  // R6: nothing follows the final descriptor directly
  a_r6_last_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);
endmodule

bind seg_splitter seg_splitter_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .ALIGN_MASK(ALIGN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
  .out_last(out_last), .err(err)
);

// File: tb/seg_splitter_bench.sv
`timescale 1ns/1ps
module seg_splitter_bench;
  localparam int MAXL = 8191;
  localparam int LIM  = MAXL & ~3;
  localparam int NV   = 6;
  localparam logic [31:0] VA [NV] = '{32'h0000_1000, 32'h0001_0000, 32'h0002_0004,
                                      32'h0003_0000, 32'h0004_0008, 32'h0005_0000};
  localparam logic [15:0] VL [NV] = '{16'h0004, 16'h1FFF, 16'h2000,
                                      16'h3FF7, 16'h5000, 16'hFFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [15:0] in_len = '0;
  logic        in_last = 1'b0;
  logic        cyc_mode = 1'b0;
  logic [15:0] cyc_period = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [15:0] out_len;
  logic        out_last;
  logic        err;
  logic [23:0] total_size;
  logic [15:0] period_descs;

  seg_splitter u_seg_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_last(in_last),
    .cyc_mode(cyc_mode), .cyc_period(cyc_period),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_len(out_len), .out_last(out_last), .err(err),
    .total_size(total_size), .period_descs(period_descs)
  );

  int checks = 0;
  int failures = 0;

  logic [31:0] got_a [256];
  logic [15:0] got_l [256];
  logic        got_t [256];
  int got_n = 0;
  int err_n = 0;
  int busy_bad = 0;
  int tick = 0;
  bit stall = 1'b0;

  always @(negedge clk) begin
    tick++;
    out_ready = !stall || (tick % 3 == 0);
    if (out_valid && out_ready && got_n < 256) begin
      got_a[got_n] = out_addr;
      got_l[got_n] = out_len;
      got_t[got_n] = out_last;
      got_n++;
    end
    if (err) err_n++;
    if (out_valid && in_ready) busy_bad++;
  end

  logic [31:0] exp_a [256];
  logic [15:0] exp_l [256];
  logic        exp_t [256];
  int exp_n = 0;

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish (act=hung exp=done)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input int len);
    int l = len;
    logic [31:0] p = a;
    while (l > 0) begin
      int t = l;
      if (t > MAXL) begin
        int m = (t + LIM - 1) / LIM;
        t = (t / m) & ~3;
      end
      exp_a[exp_n] = p;
      exp_l[exp_n] = 16'(t);
      exp_t[exp_n] = 1'b0;
      exp_n++;
      p = p + 32'(t);
      l = l - t;
    end
  endtask

  task automatic mark_last();
    exp_t[exp_n-1] = 1'b1;
  endtask

  task automatic send(input logic [31:0] a, input logic [15:0] l, input bit last,
                      input bit cm = 1'b0, input logic [15:0] p = 16'h0);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_len = l; in_last = last;
    cyc_mode = cm; cyc_period = p;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; cyc_mode = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    @(negedge clk);
    while (!(in_ready && !out_valid) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, tag, 32'(n), 32'd5000);
  endtask

  task automatic compare(input string tag, input int gb, input int eb);
    chk((got_n - gb) == (exp_n - eb), {tag, " count"}, 32'(got_n - gb), 32'(exp_n - eb));
    if ((got_n - gb) == (exp_n - eb))
      for (int i = 0; i < exp_n - eb; i++) begin
        chk(got_a[gb+i] == exp_a[eb+i], {tag, " addr"}, got_a[gb+i], exp_a[eb+i]);
        chk(got_l[gb+i] == exp_l[eb+i] && got_t[gb+i] == exp_t[eb+i], {tag, " len/last"},
            {15'd0, got_t[gb+i], got_l[gb+i]}, {15'd0, exp_t[eb+i], exp_l[eb+i]});
      end
  endtask

  initial begin
    int gb, eb, eb0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(in_ready == 1'b1, "R11 in_ready", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 32'd0);
    chk(err == 1'b0, "R11 err", 32'(err), 32'd0);
    chk(total_size == '0, "R11 total_size", 32'(total_size), 32'd0);

    // R1 R2 R3 R6 R7: single-segment lists from the table
    for (int v = 0; v < NV; v++) begin
      gb = got_n; eb = exp_n;
      model(VA[v], int'(VL[v]));
      mark_last();
      send(VA[v], VL[v], 1'b1);
      wait_idle("R2 table idle");
      compare("R1 R2 R3 table", gb, eb);
      chk(total_size == 24'(VL[v]), "R7 table total", 32'(total_size), 32'(VL[v]));
    end

    // R6 R7: two-segment list, last only on the final piece
    gb = got_n; eb = exp_n;
    model(32'h0000_8000, 16);
    model(32'h0002_0000, 16'h4000);
    mark_last();
    send(32'h0000_8000, 16'h0010, 1'b0);
    send(32'h0002_0000, 16'h4000, 1'b1);
    wait_idle("R6 multi idle");
    compare("R6 multi", gb, eb);
    chk(total_size == 24'h4010, "R7 multi total", 32'(total_size), 32'h4010);

    // R10: stalled output, long segment
    stall = 1'b1;
    gb = got_n; eb = exp_n;
    model(32'h0006_0000, 16'h5000);
    mark_last();
    send(32'h0006_0000, 16'h5000, 1'b1);
    wait_idle("R10 stall idle");
    compare("R10 stall", gb, eb);
    stall = 1'b0;
    chk(busy_bad == 0, "R10 in_ready low while busy", 32'(busy_bad), 32'd0);

    // R4: misaligned single segment
    gb = got_n; eb = err_n;
    send(32'h0000_0102, 16'h0040, 1'b1);
    wait_idle("R4 idle");
    chk(got_n == gb, "R4 no descriptors", 32'(got_n - gb), 32'd0);
    chk(err_n - eb == 1, "R4 err pulse", 32'(err_n - eb), 32'd1);
    chk(total_size == '0, "R7 total after reject", 32'(total_size), 32'd0);

    // R4: error mid-list, rest dropped through last
    gb = got_n; eb0 = exp_n; eb = err_n;
    model(32'h0000_0200, 16'h0040);
    send(32'h0000_0200, 16'h0040, 1'b0);
    send(32'h0000_0301, 16'h0040, 1'b0);
    send(32'h0000_0400, 16'h0040, 1'b1);
    wait_idle("R4 mid idle");
    compare("R4 mid-list", gb, eb0);
    chk(err_n - eb == 1, "R4 mid err", 32'(err_n - eb), 32'd1);

    // R7: next list restarts the total
    gb = got_n; eb0 = exp_n;
    model(32'h0000_0500, 16'h0010);
    mark_last();
    send(32'h0000_0500, 16'h0010, 1'b1);
    wait_idle("R7 restart idle");
    compare("R7 restart", gb, eb0);
    chk(total_size == 24'h10, "R7 restart total", 32'(total_size), 32'h10);

    // R5: zero-length segment
    gb = got_n; eb = err_n;
    send(32'h0000_0600, 16'h0000, 1'b1);
    wait_idle("R5 idle");
    chk(got_n == gb, "R5 no descriptors", 32'(got_n - gb), 32'd0);
    chk(err_n - eb == 1, "R5 err pulse", 32'(err_n - eb), 32'd1);

    // R8 R9: cyclic, period 0x3000, size 0x9000 -> 3 periods of 2
    gb = got_n; eb0 = exp_n;
    for (int k = 0; k < 3; k++) model(32'h0010_0000 + 32'(k * 32'h3000), 16'h3000);
    mark_last();
    send(32'h0010_0000, 16'h9000, 1'b1, 1'b1, 16'h3000);
    wait_idle("R8 cyclic idle");
    compare("R8 cyclic", gb, eb0);
    chk(period_descs == 16'd2, "R9 period_descs", 32'(period_descs), 32'd2);

    // R8 R9: size not a multiple of period -> floor periods
    gb = got_n; eb0 = exp_n;
    for (int k = 0; k < 2; k++) model(32'h0020_0000 + 32'(k * 32'h1000), 16'h1000);
    mark_last();
    send(32'h0020_0000, 16'h2800, 1'b1, 1'b1, 16'h1000);
    wait_idle("R8 floor idle");
    compare("R8 floor", gb, eb0);
    chk(period_descs == 16'd1, "R9 period_descs one", 32'(period_descs), 32'd1);

    // R9: size smaller than period rejected
    gb = got_n; eb = err_n;
    send(32'h0030_0000, 16'h2000, 1'b1, 1'b1, 16'h3000);
    wait_idle("R9 reject idle");
    chk(got_n == gb, "R9 no descriptors", 32'(got_n - gb), 32'd0);
    chk(err_n - eb == 1, "R9 err pulse", 32'(err_n - eb), 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule